// File: doc/BRIEF.md
# Switch State Reporting Peripheral

This block lets a processor observe one named switch. Hardware delivers a new 32-bit switch state on a one-cycle update strobe. The block stores that word, marks a change as pending and drives a level interrupt whenever a change is pending and interrupts are enabled. The processor reads the state, then reads the interrupt status register to acknowledge. The acknowledge takes effect only while the interrupt is enabled, so a change that arrives while interrupts are off stays pending and raises the line as soon as software turns the enable on.

A switch built with output capability also lets the processor write the state register. The written word is shown on an output strobe. The driven side returns, in the same cycle, the value it actually took. The stored state is replaced, and a change flagged, only when that returned value differs from the current state. Capability and the name length are fixed by parameters and can be read back as constants. Bus accesses take one cycle. Read data and the error strobe appear in the cycle after the access.

Top module: `sw_status_periph`

## Requirements
- R1: After reset the state word is 0, no change is pending, interrupts are disabled and `irq` is low. A status read then returns 0.
- R2: A read at byte offset 0x00 returns the `NAME_LEN` parameter. A read at 0x08 returns `OUT_CAP` in bit 0 and 0 in every other bit.
- R3: A cycle with `hw_upd_valid` high stores `hw_upd_data` as the state, which a read at offset 0x0C returns. It also sets the pending flag. If interrupts are enabled, `irq` is high from the next cycle.
- R4: A read at offset 0x10 while a change is pending and interrupts are enabled returns 1, clears the pending flag and drops `irq` on the next cycle. In every other case the read returns 0 and leaves the pending flag alone.
- R5: A write at offset 0x14 keeps only bit 0 of the data as the enable. While a change is pending, `irq` follows the new enable value from the next cycle.
- R6: On an output-capable block, a write at offset 0x0C raises `out_valid` in that same cycle, with `out_data` equal to the write data. The state becomes `out_accept` only when `out_accept` differs from the current state. Only in that case is the pending flag set, with an interrupt if enabled.
- R7: An error access raises `bus_err` for exactly the one cycle after it and changes no register. Read data after an error read is 0. Error accesses are: a write at 0x0C on an input-only block, a read at a write-only offset (0x04, 0x14), a write at a read-only offset (0x00, 0x08, 0x10), or any other offset, including misaligned ones.
- R8: When a hardware update coincides with an acknowledging status read, the update wins. The read still returns 1, but the pending flag stays set and `irq` stays high.
- R9: A write at offset 0x04 is accepted without error and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Single-cycle register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle error strobe after a bad access |
| hw_upd_valid | input | 1 | Hardware state update strobe |
| hw_upd_data | input | 32 | New switch state from hardware |
| out_valid | output | 1 | A processor write is being presented to the driven side |
| out_data | output | 32 | Value presented to the driven side |
| out_accept | input | 32 | Value the driven side took, returned in the same cycle |
| irq | output | 1 | Level interrupt |

## Verification
A pending flag that is wrong shows up one cycle later on `irq` once the enable is set, or as an unexpected 0 or 1 from the status read. An enable bit that is wrong shows up when a pending change fails to raise, or fails to drop, the line on the next cycle. A corrupted state word appears in the next read of offset 0x0C. A missed change detection on the output path shows up as an interrupt that should not be there, or is missing, one cycle after the write. An error access that is handled wrongly shows up as a misplaced `bus_err` pulse or as a register that changed.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int unsigned SW_AW = 12;
    localparam int unsigned SW_DW = 32;

    localparam logic [SW_AW-1:0] OFS_NLEN  = 12'h000;
    localparam logic [SW_AW-1:0] OFS_NPTR  = 12'h004;
    localparam logic [SW_AW-1:0] OFS_CAPS  = 12'h008;
    localparam logic [SW_AW-1:0] OFS_STATE = 12'h00C;
    localparam logic [SW_AW-1:0] OFS_ISTAT = 12'h010;
    localparam logic [SW_AW-1:0] OFS_IEN   = 12'h014;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_NLEN,
        OP_RD_CAPS,
        OP_RD_STATE,
        OP_RD_ISTAT,
        OP_WR_NPTR,
        OP_WR_STATE,
        OP_WR_IEN,
        OP_BAD
    } sw_op_e;

    typedef struct packed {
        logic [SW_DW-1:0] state;
        logic             pend;
        logic             en;
        logic             irq;
        logic             err;
        logic [SW_DW-1:0] rdata;
    } sw_regs_t;
endpackage

// File: rtl/sw_decode.sv
module sw_decode
    import sw_pkg::*;
#(
    parameter bit OUT_CAP = 1'b1
) (
    input  logic             sel,
    input  logic             we,
    input  logic [SW_AW-1:0] addr,
    output sw_op_e           op
);
    sw_op_e wr_state_op;

    generate
        if (OUT_CAP) begin : g_out
            assign wr_state_op = OP_WR_STATE;
        end else begin : g_in
            assign wr_state_op = OP_BAD;
        end
    endgenerate

    always_comb begin
        op = OP_NONE;
        if (sel) begin
            if (we) begin
                case (addr)
                    OFS_NPTR:  op = OP_WR_NPTR;
                    OFS_STATE: op = wr_state_op;
                    OFS_IEN:   op = OP_WR_IEN;
                    default:   op = OP_BAD;
                endcase
            end else begin
                case (addr)
                    OFS_NLEN:  op = OP_RD_NLEN;
                    OFS_CAPS:  op = OP_RD_CAPS;
                    OFS_STATE: op = OP_RD_STATE;
                    OFS_ISTAT: op = OP_RD_ISTAT;
                    default:   op = OP_BAD;
                endcase
            end
        end
    end
endmodule

// File: rtl/sw_rdmux.sv
module sw_rdmux
    import sw_pkg::*;
#(
    parameter bit              OUT_CAP  = 1'b1,
    parameter logic [SW_DW-1:0] NAME_LEN = 32'd8
) (
    input  sw_op_e           op,
    input  logic [SW_DW-1:0] state,
    input  logic             pend,
    input  logic             en,
    output logic [SW_DW-1:0] rd_val
);
    localparam logic [SW_DW-1:0] CAPS_WORD = {{(SW_DW-1){1'b0}}, OUT_CAP};

    always_comb begin
        case (op)
            OP_RD_NLEN:  rd_val = NAME_LEN;
            OP_RD_CAPS:  rd_val = CAPS_WORD;
            OP_RD_STATE: rd_val = state;
            OP_RD_ISTAT: rd_val = {{(SW_DW-1){1'b0}}, pend & en};
            default:     rd_val = '0;
        endcase
    end
endmodule

// File: rtl/sw_core.sv
module sw_core
    import sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sw_op_e           op,
    input  logic             ien_bit,
    input  logic [SW_DW-1:0] out_accept,
    input  logic             hw_valid,
    input  logic [SW_DW-1:0] hw_data,
    input  logic [SW_DW-1:0] rd_val,
    output logic [SW_DW-1:0] state_o,
    output logic             pend_o,
    output logic             en_o,
    output logic             irq_o,
    output logic             err_o,
    output logic [SW_DW-1:0] rdata_o
);
    sw_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.err = (op == OP_BAD);
        if (op != OP_NONE) begin
            r_d.rdata = rd_val;
        end
        case (op)
            OP_RD_ISTAT: begin
                if (r_q.pend && r_q.en) begin
                    r_d.pend = 1'b0;
                    r_d.irq  = 1'b0;
                end
            end
            OP_WR_IEN: begin
                if (r_q.pend && (r_q.en != ien_bit)) begin
                    r_d.irq = ien_bit;
                end
                r_d.en = ien_bit;
            end
            OP_WR_STATE: begin
                if (out_accept != r_q.state) begin
                    r_d.state = out_accept;
                    r_d.pend  = 1'b1;
                    if (r_d.en) begin
                        r_d.irq = 1'b1;
                    end
                end
            end
            default: ;
        endcase
        if (hw_valid) begin
            r_d.state = hw_data;
            r_d.pend  = 1'b1;
            if (r_d.en) begin
                r_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign pend_o  = r_q.pend;
    assign en_o    = r_q.en;
    assign irq_o   = r_q.irq;
    assign err_o   = r_q.err;
    assign rdata_o = r_q.rdata;

    AST_HW_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid |=> r_q.pend); // R3
    AST_HW_IRQ_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid |=> (r_q.irq == r_q.en)); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_ISTAT && r_q.pend && r_q.en && !hw_valid) |=> (!r_q.pend && !r_q.irq)); // R4
    AST_NOACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_ISTAT && !(r_q.pend && r_q.en)) |=> $stable(r_q.pend)); // R4
    AST_IEN_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_IEN && r_q.pend && !hw_valid) |=> (r_q.irq == r_q.en)); // R5
    AST_SAME_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_STATE && out_accept == r_q.state && !r_q.pend && !hw_valid) |=> !r_q.pend); // R6
    AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BAD && !hw_valid) |=> ($stable(r_q.state) && $stable(r_q.pend) && $stable(r_q.en) && $stable(r_q.irq))); // R7
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.err && op != OP_BAD) |=> !r_q.err); // R7
    AST_UPDATE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_ISTAT && hw_valid) |=> r_q.pend); // R8
endmodule

// File: rtl/sw_status_periph.sv
module sw_status_periph
    import sw_pkg::*;
#(
    parameter bit               OUT_CAP  = 1'b1,
    parameter logic [SW_DW-1:0] NAME_LEN = 32'd8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [SW_AW-1:0] bus_addr,
    input  logic [SW_DW-1:0] bus_wdata,
    output logic [SW_DW-1:0] bus_rdata,
    output logic             bus_err,
    input  logic             hw_upd_valid,
    input  logic [SW_DW-1:0] hw_upd_data,
    output logic             out_valid,
    output logic [SW_DW-1:0] out_data,
    input  logic [SW_DW-1:0] out_accept,
    output logic             irq
);
    sw_op_e           op;
    logic [SW_DW-1:0] rd_val;
    logic [SW_DW-1:0] state_w;
    logic             pend_w;
    logic             en_w;

    sw_decode #(.OUT_CAP(OUT_CAP)) u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .op   (op)
    );

    sw_rdmux #(.OUT_CAP(OUT_CAP), .NAME_LEN(NAME_LEN)) u_mux (
        .op     (op),
        .state  (state_w),
        .pend   (pend_w),
        .en     (en_w),
        .rd_val (rd_val)
    );

    sw_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .ien_bit    (bus_wdata[0]),
        .out_accept (out_accept),
        .hw_valid   (hw_upd_valid),
        .hw_data    (hw_upd_data),
        .rd_val     (rd_val),
        .state_o    (state_w),
        .pend_o     (pend_w),
        .en_o       (en_w),
        .irq_o      (irq),
        .err_o      (bus_err),
        .rdata_o    (bus_rdata)
    );

    assign out_valid = (op == OP_WR_STATE);
    assign out_data  = bus_wdata;
endmodule

// File: tb/sim_sw_status_periph.sv
`timescale 1ns/1ps
module sim_sw_status_periph;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel0 = 1'b0, sel1 = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        hw_v = 1'b0;
    logic [31:0] hw_d = '0;
    logic [31:0] acc = '0;
    logic [31:0] rdata0, rdata1, od0, od1;
    logic        err0, err1, ov0, ov1, irq0, irq1;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;
    logic        ov_seen;
    logic [31:0] od_seen;

    always #4 clk = ~clk;

    sw_status_periph #(.OUT_CAP(1'b1), .NAME_LEN(32'd11)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .bus_err(err0),
        .hw_upd_valid(hw_v), .hw_upd_data(hw_d), .out_valid(ov0), .out_data(od0),
        .out_accept(acc), .irq(irq0));

    sw_status_periph #(.OUT_CAP(1'b0), .NAME_LEN(32'd6)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .bus_err(err1),
        .hw_upd_valid(1'b0), .hw_upd_data(32'h0), .out_valid(ov1), .out_data(od1),
        .out_accept(32'h0), .irq(irq1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access; afterwards rdata/err reflect it (sampled at the following negedge)
    task automatic access(input bit dev, input bit w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel0 = !dev; sel1 = dev; we = w; addr = a; wdata = d;
        #1;
        ov_seen = ov0; od_seen = od0;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; we = 1'b0;
    endtask

    task automatic hw_update(input logic [31:0] d);
        @(negedge clk);
        hw_v = 1'b1; hw_d = d;
        @(negedge clk);
        hw_v = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 irq after reset", {31'b0, irq0}, 32'd0);
        access(0, 0, 12'h00C, 0); chk("R1 state after reset", rdata0, 32'd0);
        access(0, 0, 12'h010, 0); chk("R1 status after reset", rdata0, 32'd0);
    endtask

    task automatic t_consts;
        access(0, 0, 12'h000, 0); chk("R2 name length u0", rdata0, 32'd11);
        access(0, 0, 12'h008, 0); chk("R2 caps u0", rdata0, 32'd1);
        access(1, 0, 12'h000, 0); chk("R2 name length u1", rdata1, 32'd6);
        access(1, 0, 12'h008, 0); chk("R2 caps u1", rdata1, 32'd0);
    endtask

    task automatic t_disabled_pending;
        hw_update(32'hA5A5_0001);
        chk("R3 irq stays low while disabled", {31'b0, irq0}, 32'd0);
        access(0, 0, 12'h00C, 0); chk("R3 state after update", rdata0, 32'hA5A5_0001);
        access(0, 0, 12'h010, 0); chk("R4 status read while disabled", rdata0, 32'd0);
        access(0, 1, 12'h014, 32'h1); chk("R5 enable raises pending irq", {31'b0, irq0}, 32'd1);
        access(0, 1, 12'h014, 32'h2); chk("R5 only bit0 kept, irq drops", {31'b0, irq0}, 32'd0);
        access(0, 1, 12'h014, 32'h3); chk("R5 bit0 set re-raises irq", {31'b0, irq0}, 32'd1);
        access(0, 0, 12'h010, 0); chk("R4 ack returns 1", rdata0, 32'd1);
        chk("R4 ack drops irq", {31'b0, irq0}, 32'd0);
        access(0, 0, 12'h010, 0); chk("R4 second status read", rdata0, 32'd0);
    endtask

    task automatic t_enabled_update;
        hw_update(32'h0000_BEEF);
        chk("R3 irq raised when enabled", {31'b0, irq0}, 32'd1);
        access(0, 0, 12'h010, 0); chk("R4 ack after enabled update", rdata0, 32'd1);
        chk("R4 irq low after ack", {31'b0, irq0}, 32'd0);
    endtask

    task automatic t_output;
        acc = 32'h0000_1234;
        access(0, 1, 12'h00C, 32'h0000_1234);
        chk("R6 out_valid with write", {31'b0, ov_seen}, 32'd1);
        chk("R6 out_data with write", od_seen, 32'h0000_1234);
        chk("R6 changed value raises irq", {31'b0, irq0}, 32'd1);
        access(0, 0, 12'h00C, 0); chk("R6 state takes accepted value", rdata0, 32'h0000_1234);
        access(0, 0, 12'h010, 0); chk("R6 ack", rdata0, 32'd1);
        acc = 32'h0000_1234;
        access(0, 1, 12'h00C, 32'h0000_9999);
        chk("R6 out_data shows written word", od_seen, 32'h0000_9999);
        chk("R6 unchanged value no irq", {31'b0, irq0}, 32'd0);
        access(0, 0, 12'h010, 0); chk("R6 unchanged value no pending", rdata0, 32'd0);
        acc = 32'h0000_0007;
        access(0, 1, 12'h00C, 32'h0000_0005);
        access(0, 0, 12'h00C, 0); chk("R6 accepted differs from written", rdata0, 32'h0000_0007);
        access(0, 0, 12'h010, 0); chk("R6 ack again", rdata0, 32'd1);
    endtask

    task automatic t_errors;
        access(1, 1, 12'h00C, 32'h55);
        chk("R7 err on input-only state write", {31'b0, err1}, 32'd1);
        @(negedge clk); chk("R7 err lasts one cycle", {31'b0, err1}, 32'd0);
        access(1, 0, 12'h00C, 0); chk("R7 input-only state unchanged", rdata1, 32'd0);
        access(0, 0, 12'h018, 0);
        chk("R7 err on undefined offset", {31'b0, err0}, 32'd1);
        chk("R7 bad read data zero", rdata0, 32'd0);
        access(0, 0, 12'h014, 0); chk("R7 err on write-only read", {31'b0, err0}, 32'd1);
        access(0, 1, 12'h010, 32'h1); chk("R7 err on read-only write", {31'b0, err0}, 32'd1);
        access(0, 0, 12'h00D, 0); chk("R7 err on misaligned", {31'b0, err0}, 32'd1);
        access(0, 0, 12'h00C, 0);
        chk("R7 no err on good read", {31'b0, err0}, 32'd0);
        chk("R7 state unchanged by errors", rdata0, 32'h0000_0007);
        access(0, 0, 12'h010, 0); chk("R7 no pending from errors", rdata0, 32'd0);
    endtask

    task automatic t_name_ptr;
        access(0, 1, 12'h004, 32'h8000_0000);
        chk("R9 name pointer write no err", {31'b0, err0}, 32'd0);
        access(0, 0, 12'h00C, 0); chk("R9 state unchanged", rdata0, 32'h0000_0007);
        chk("R9 irq unchanged", {31'b0, irq0}, 32'd0);
    endtask

    task automatic t_priority;
        hw_update(32'h0000_0011);
        chk("R8 setup irq", {31'b0, irq0}, 32'd1);
        @(negedge clk);
        sel0 = 1'b1; we = 1'b0; addr = 12'h010; hw_v = 1'b1; hw_d = 32'h0000_0077;
        @(negedge clk);
        sel0 = 1'b0; hw_v = 1'b0;
        chk("R8 read still returns 1", rdata0, 32'd1);
        chk("R8 irq stays high", {31'b0, irq0}, 32'd1);
        access(0, 0, 12'h00C, 0); chk("R8 update stored", rdata0, 32'h0000_0077);
        access(0, 0, 12'h010, 0); chk("R8 still pending", rdata0, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_consts();
        t_disabled_pending();
        t_enabled_update();
        t_output();
        t_errors();
        t_name_ptr();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule